// File: doc/BRIEF.md
# Dimmable 5x5 Lamp Matrix Controller

This output peripheral keeps a frame of twenty-five pixels arranged as five rows of five, each pixel holding a 4-bit brightness. It drives one lamp output per pixel with pulse-width modulation, so a lamp can be anything from dark to fully lit in sixteen steps.

A host loads the frame through three single-cycle strobes. A select strobe claims the device and puts the write position at the top-left pixel. A byte strobe carries an 8-bit value whose low nibble becomes the brightness of the next pixel in the current row, filling left to right. A feed strobe moves writing to the start of the next row, and after the bottom row it returns to the top. A PWM step counter advances once every `STEP_CYCLES` clocks, which sets the length of a 16-step dimming frame.

Top module: `lamp_matrix_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, every pixel holds level 0, every lamp output is low and the write position is row 0, column 0.
- R2: A byte strobe stores bits [3:0] of the data at the current row and column and then moves the column right by one; bits [7:4] have no effect on any lamp.
- R3: Once five bytes have been stored in a row, further byte strobes change no pixel until the next feed or select.
- R4: A feed strobe sets the column to 0 and moves to the next row; a feed while on row 4 moves to row 0.
- R5: A select strobe sets the write position to row 0, column 0 at any time and leaves stored pixels unchanged.
- R6: When strobes coincide in one cycle, select takes precedence over feed and byte, and feed takes precedence over byte; the strobe that loses is dropped entirely.
- R7: The PWM step counter starts at 0 after reset and increments (mod 16) every `STEP_CYCLES` clocks; a lamp is lit while the counter is below its pixel's level, so level L (0 to 14) is lit for L*STEP_CYCLES clocks of every 16*STEP_CYCLES, and level 0 is never lit.
- R8: A pixel at level 15 keeps its lamp lit in every cycle.
- R9: The pixel at row r, column c drives lamp output bit r*5+c.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_stb | input | 1 | Device select strobe; write position to top-left |
| wr_stb | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte value; low nibble is the brightness |
| feed_stb | input | 1 | New-row strobe |
| lamp_o | output | 25 | Lamp drive, bit r*5+c for row r, column c |

## Verification
The bench drives overflowing rows, a feed from the bottom row, a select in the middle of a row and every pairing of coincident strobes. A design that let a sixth byte through would corrupt the next row's first pixel or wrap within the row; one that forgot the row wrap would write into a nonexistent row and lose data; one with the wrong strobe precedence would store a byte that should vanish. A full ramp of levels 0 to 15 is then measured over a whole PWM frame, which exposes an off-by-one compare, a level 15 that blinks once per frame, or a swapped pixel-to-lamp mapping.

// File: rtl/lmx_pkg.sv
package lmx_pkg;

  localparam int unsigned LVL_W   = 4;
  localparam int unsigned LVL_MAX = (1 << LVL_W) - 1;

  typedef logic [LVL_W-1:0] level_t;

  // Lamp state for one pixel at one PWM step.
  function automatic logic lamp_lit(input level_t lvl, input level_t step);
    return (lvl == level_t'(LVL_MAX)) || (step < lvl);
  endfunction

  // Next index with wrap to zero at lim.
  function automatic int unsigned wrap_next(input int unsigned v, input int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/lmx_cursor.sv
module lmx_cursor #(
  parameter int unsigned ROWS  = 5,
  parameter int unsigned COLS  = 5,
  parameter int unsigned ROW_W = $clog2(ROWS),
  parameter int unsigned COL_W = $clog2(COLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_fire,
  input  logic             feed_fire,
  input  logic             wr_fire,
  output logic [ROW_W-1:0] cur_row,
  output logic [COL_W-1:0] cur_col,
  output logic             wr_accept
);

  assign wr_accept = wr_fire && (cur_col < COL_W'(COLS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_row <= '0;
      cur_col <= '0;
    end else if (sel_fire) begin
      cur_row <= '0;
      cur_col <= '0;
    end else if (feed_fire) begin
      cur_row <= ROW_W'(lmx_pkg::wrap_next(int'(cur_row), ROWS));
      cur_col <= '0;
    end else if (wr_accept) begin
      cur_col <= cur_col + COL_W'(1);
    end
  end

endmodule

// File: rtl/lmx_frame_store.sv
module lmx_frame_store #(
  parameter int unsigned ROWS  = 5,
  parameter int unsigned COLS  = 5,
  parameter int unsigned ROW_W = $clog2(ROWS),
  parameter int unsigned COL_W = $clog2(COLS + 1),
  localparam int unsigned NPIX = ROWS * COLS,
  localparam int unsigned LW   = lmx_pkg::LVL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ROW_W-1:0]   row,
  input  logic [COL_W-1:0]   col,
  input  lmx_pkg::level_t    level,
  output logic [NPIX*LW-1:0] pix_flat
);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int unsigned IDX = r * COLS + c;
      lmx_pkg::level_t cell_q;
      logic            hit;

      assign hit = wr_en && (row == ROW_W'(r)) && (col == COL_W'(c));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cell_q <= '0;
        else if (hit) cell_q <= level;
      end

      assign pix_flat[IDX*LW +: LW] = cell_q;
    end
  end

endmodule

// File: rtl/lmx_pwm.sv
module lmx_pwm #(
  parameter int unsigned NPIX        = 25,
  parameter int unsigned STEP_CYCLES = 4,
  localparam int unsigned LW   = lmx_pkg::LVL_W,
  localparam int unsigned PS_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPIX*LW-1:0] pix_flat,
  output lmx_pkg::level_t    step_cnt,
  output logic               step_tick,
  output logic [NPIX-1:0]    lamp
);

  logic [PS_W-1:0] pre_q;

  assign step_tick = (pre_q == PS_W'(STEP_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q    <= '0;
      step_cnt <= '0;
    end else if (step_tick) begin
      pre_q    <= '0;
      step_cnt <= step_cnt + 1'b1;
    end else begin
      pre_q    <= pre_q + PS_W'(1);
    end
  end

  for (genvar i = 0; i < NPIX; i++) begin : g_lamp
    assign lamp[i] = lmx_pkg::lamp_lit(pix_flat[i*LW +: LW], step_cnt);
  end

endmodule

// File: rtl/lamp_matrix_ctrl.sv
module lamp_matrix_ctrl #(
  parameter int unsigned ROWS        = 5,
  parameter int unsigned COLS        = 5,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned STEP_CYCLES = 4,
  localparam int unsigned NPIX  = ROWS * COLS,
  localparam int unsigned LW    = lmx_pkg::LVL_W,
  localparam int unsigned ROW_W = $clog2(ROWS),
  localparam int unsigned COL_W = $clog2(COLS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_stb,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              feed_stb,
  output logic [NPIX-1:0]   lamp_o
);

  // Named events for the checker.
  logic               sel_fire;
  logic               feed_fire;
  logic               wr_fire;
  logic               wr_accept;
  logic [ROW_W-1:0]   cur_row;
  logic [COL_W-1:0]   cur_col;
  logic [NPIX*LW-1:0] pix_flat;
  lmx_pkg::level_t    step_cnt;
  logic               step_tick;
  lmx_pkg::level_t    wr_level;

  assign sel_fire  = sel_stb;
  assign feed_fire = feed_stb && !sel_stb;
  assign wr_fire   = wr_stb && !sel_stb && !feed_stb;
  assign wr_level  = wr_data[LW-1:0];

  lmx_cursor #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_cursor (
    .clk(clk), .rst_n(rst_n),
    .sel_fire(sel_fire), .feed_fire(feed_fire), .wr_fire(wr_fire),
    .cur_row(cur_row), .cur_col(cur_col), .wr_accept(wr_accept)
  );

  lmx_frame_store #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_accept), .row(cur_row), .col(cur_col), .level(wr_level),
    .pix_flat(pix_flat)
  );

  lmx_pwm #(.NPIX(NPIX), .STEP_CYCLES(STEP_CYCLES)) u_pwm (
    .clk(clk), .rst_n(rst_n),
    .pix_flat(pix_flat), .step_cnt(step_cnt), .step_tick(step_tick),
    .lamp(lamp_o)
  );

endmodule

// File: rtl/lamp_matrix_ctrl_chk.sv
module lamp_matrix_ctrl_chk #(
  parameter int unsigned ROWS  = 5,
  parameter int unsigned COLS  = 5,
  localparam int unsigned NPIX  = ROWS * COLS,
  localparam int unsigned LW    = lmx_pkg::LVL_W,
  localparam int unsigned ROW_W = $clog2(ROWS),
  localparam int unsigned COL_W = $clog2(COLS + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sel_stb,
  input logic               wr_stb,
  input logic               feed_stb,
  input logic               wr_fire,
  input logic               feed_fire,
  input logic [ROW_W-1:0]   cur_row,
  input logic [COL_W-1:0]   cur_col,
  input logic [NPIX*LW-1:0] pix_flat,
  input lmx_pkg::level_t    step_cnt,
  input logic               step_tick,
  input logic [NPIX-1:0]    lamp_o
);

  // R2
  col_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && cur_col < COL_W'(COLS)) |=> cur_col == $past(cur_col) + COL_W'(1));

  // R3
  full_row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && cur_col == COL_W'(COLS)) |=> ($stable(pix_flat) && $stable(cur_col)));

  // R4
  feed_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    feed_fire |=> (cur_col == '0 &&
                   cur_row == (($past(cur_row) == ROW_W'(ROWS - 1)) ? '0 : $past(cur_row) + ROW_W'(1))));

  // R4
  row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_row < ROW_W'(ROWS));

  // R5
  sel_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_stb |=> (cur_row == '0 && cur_col == '0 && $stable(pix_flat)));

  // R6
  feed_beats_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (feed_stb && wr_stb) |=> $stable(pix_flat));

  // R7
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_tick |=> $stable(step_cnt));

  for (genvar i = 0; i < NPIX; i++) begin : g_pix
    // R8
    full_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_flat[i*LW +: LW] == lmx_pkg::level_t'(lmx_pkg::LVL_MAX)) |-> lamp_o[i]);
    // R7
    dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_flat[i*LW +: LW] == '0) |-> !lamp_o[i]);
  end

endmodule

bind lamp_matrix_ctrl lamp_matrix_ctrl_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .sel_stb(sel_stb), .wr_stb(wr_stb), .feed_stb(feed_stb),
  .wr_fire(wr_fire), .feed_fire(feed_fire),
  .cur_row(cur_row), .cur_col(cur_col),
  .pix_flat(pix_flat), .step_cnt(step_cnt), .step_tick(step_tick),
  .lamp_o(lamp_o)
);

// File: tb/lamp_matrix_ctrl_test.sv
`timescale 1ns/1ps
module lamp_matrix_ctrl_test;

  localparam int STEP = 4;
  localparam int NP   = 25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_stb = 1'b0;
  logic        wr_stb = 1'b0;
  logic        feed_stb = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [24:0] lamp_o;

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag = "R1";
  bit    done = 1'b0;

  // Behavioural reference state.
  int m_pix[NP];
  int m_row = 0, m_col = 0, m_pre = 0, m_step = 0;

  always #4 clk = ~clk;

  lamp_matrix_ctrl #(.STEP_CYCLES(STEP)) uut (
    .clk(clk), .rst_n(rst_n), .sel_stb(sel_stb), .wr_stb(wr_stb),
    .wr_data(wr_data), .feed_stb(feed_stb), .lamp_o(lamp_o)
  );

  initial foreach (m_pix[i]) m_pix[i] = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_pix[i]) m_pix[i] = 0;
      m_row = 0; m_col = 0; m_pre = 0; m_step = 0;
    end else begin
      if (sel_stb) begin
        m_row = 0; m_col = 0;
      end else if (feed_stb) begin
        m_col = 0;
        m_row = (m_row == 4) ? 0 : m_row + 1;
      end else if (wr_stb && m_col < 5) begin
        m_pix[m_row*5 + m_col] = wr_data % 16;
        m_col++;
      end
      if (m_pre == STEP - 1) begin
        m_pre = 0;
        m_step = (m_step + 1) % 16;
      end else m_pre++;
    end
  end

  function automatic logic [24:0] model_lamps();
    logic [24:0] v;
    for (int i = 0; i < NP; i++) v[i] = (m_pix[i] == 15) || (m_step < m_pix[i]);
    return v;
  endfunction

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if (lamp_o !== model_lamps()) begin
        n_bad++;
        $display("FAIL %s: lamps actual %h expected %h", tag, lamp_o, model_lamps());
      end
    end
  end

  task automatic strobe(input bit s, input bit f, input bit w, input logic [7:0] d);
    @(negedge clk); #1;
    sel_stb = s; feed_stb = f; wr_stb = w; wr_data = d;
    @(negedge clk); #1;
    sel_stb = 0; feed_stb = 0; wr_stb = 0; wr_data = 8'h00;
  endtask

  task automatic put(input logic [7:0] d); strobe(0, 0, 1, d); endtask
  task automatic feed(); strobe(0, 1, 0, 8'h00); endtask
  task automatic sel(); strobe(1, 0, 0, 8'h00); endtask

  task automatic check_eq(input string r, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  // Measure on-time of every lamp over one full PWM frame.
  task automatic duty_check(input string r);
    int on_cnt[NP];
    foreach (on_cnt[i]) on_cnt[i] = 0;
    for (int k = 0; k < 16*STEP; k++) begin
      @(negedge clk);
      for (int i = 0; i < NP; i++) on_cnt[i] += lamp_o[i];
    end
    for (int i = 0; i < NP; i++)
      check_eq(r, on_cnt[i], (m_pix[i] == 15) ? 16*STEP : m_pix[i]*STEP);
  endtask

  initial begin
    // R1: outputs dark in reset and just after.
    repeat (3) @(negedge clk);
    check_eq("R1", int'(lamp_o), 0);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_eq("R1", int'(lamp_o), 0);
    duty_check("R1");

    // R2, R9: fill row 0 with upper nibbles set.
    tag = "R2";
    sel();
    put(8'hA3); put(8'h57); put(8'hFF); put(8'h01); put(8'hC9);
    // R3: overflow bytes dropped.
    tag = "R3";
    put(8'h0E); put(8'h0D);
    repeat (3) @(negedge clk);
    check_eq("R3", int'(lamp_o[4]), int'(m_step < 9));
    // R4: walk rows with feeds.
    tag = "R4";
    for (int r = 1; r < 5; r++) begin
      feed();
      for (int c = 0; c < 5; c++) put(8'((r*5 + c) % 16));
    end
    feed();            // wraps to row 0
    put(8'h0C);        // lands on pixel 0
    repeat (2) @(negedge clk);
    check_eq("R4", m_pix[0], 12);
    // R5: select mid-row restarts at top-left, keeps data.
    tag = "R5";
    feed(); put(8'h02); put(8'h03);
    sel(); put(8'h06);
    // R6: coincident strobes.
    tag = "R6";
    put(8'h07);
    strobe(1, 1, 1, 8'h0B);  // select wins
    put(8'h08);               // pixel 0
    strobe(0, 1, 1, 8'h0B);  // feed wins, byte dropped
    put(8'h04);               // pixel 5
    strobe(1, 0, 1, 8'h0F);  // select wins, byte dropped
    put(8'h09);               // pixel 0
    repeat (2) @(negedge clk);
    check_eq("R6", m_pix[0], 9);
    // R7, R8, R9: full ramp measured over a frame.
    tag = "R7";
    sel();
    for (int r = 0; r < 5; r++) begin
      for (int c = 0; c < 5; c++) put(8'h30 | 8'((r*5 + c) % 16));
      feed();
    end
    duty_check("R7");
    tag = "R8";
    sel();
    for (int c = 0; c < 5; c++) put(8'h0F);
    duty_check("R8");
    tag = "R9";
    sel(); feed(); feed(); feed();
    put(8'h00); put(8'h00); put(8'h00); put(8'h0F);
    duty_check("R9");
    check_eq("R9", m_pix[18], 15);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule